// File: doc/BRIEF.md
# Payload Read Request Generator

This block takes the payload fields of a descriptor that a channel sequencer has already accepted. It turns them into a series of memory read requests. Each request carries a byte address and a byte length and is offered on a valid/ready handshake. There are two ways to walk the payload.

The line mode walks a two-dimensional buffer. Every request is one line long, and the address steps forward by a stride that is stored in 16-byte units. The fragment mode walks a scatter list of up to five source addresses. Each fragment runs from its address to the next 4 KiB page boundary. Each source address is widened by a 12-bit extension field taken from one of three packed extension words.

When the sequence ends, the block pulses `done` for one cycle and leaves the running byte count on `bytes_issued` for the sequencer to read. A read error reported by the memory side stops the walk at once. It also raises a one-cycle error flag on the bit of the channel that owns the descriptor.

Top module: `pyld_rdreq_gen`

## Requirements
- R1: After reset, `req_valid`, `done` and every `data_err` bit are 0, and `bytes_issued` is 0.
- R2: In `size_stride`, bits 17:0 are the line length in bytes. Bits 31:18 are the stride in 16-byte units, so the address step in bytes is that field times 16.
- R3: Line mode (`frag_mode`=0) starts at source address 0. Each accepted request adds the stride to the address and subtracts the line length from the bytes left. The walk continues until no bytes are left.
- R4: Fragment mode (`frag_mode`=1) issues source addresses 0 to 4 in that order. Each fragment asks for 4096 minus (address mod 4096) bytes. The walk ends when the bytes left reach zero or after the fifth fragment, whichever comes first.
- R5: Source address k is the 32-bit word `src_lo[k]` plus a 12-bit extension field, zero-extended. For k = 0, 2 and 4 the field is bits 27:16 of `ext_words[k/2]`, shifted left by 20. For k = 1 and 3 the field is bits 11:0 of `ext_words[(k+1)/2]`, shifted left by 8.
- R6: No request is longer than the bytes left, and no request has length 0. The last request is shortened to the bytes left.
- R7: A request stays on `req_addr`/`req_len` unchanged, with `req_valid` high, until a cycle in which `req_ready` is high. Only one request is outstanding at a time.
- R8: A start with `xfer_size` of 0, or a start in line mode with a line length of 0, issues no request and pulses `done` in the next cycle.
- R9: If `rd_err` is high while a request is pending, no further request is issued. That pending request is not counted. In the next cycle `done` pulses together with `data_err` bit `start_ch`, and only that bit.
- R10: `bytes_issued` is cleared at each accepted start. It grows by the length of every accepted request and holds its value after `done`.
- R11: `start` is ignored while a walk is in progress.
- R12: `done` is a one-cycle pulse in the cycle after the final request is accepted, and `req_valid` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Accept the descriptor fields presented this cycle |
| start_ch | input | CH_W | Channel that owns the descriptor |
| frag_mode | input | 1 | 0 = line mode, 1 = fragment mode |
| xfer_size | input | LEN_W | Total payload bytes |
| size_stride | input | 32 | Line length [17:0], stride in 16-byte units [31:18] |
| src_lo | input | 5x32 | Low words of source addresses 0 to 4 |
| ext_words | input | 3x32 | Address extension words |
| req_valid | output | 1 | Read request present |
| req_ready | input | 1 | Memory side takes the request |
| req_addr | output | ADDR_W | Request byte address |
| req_len | output | LEN_W | Request byte length |
| rd_err | input | 1 | Data read failed |
| done | output | 1 | One-cycle end-of-walk pulse |
| data_err | output | NCH | One-cycle data error flag, one bit per channel |
| bytes_issued | output | LEN_W | Bytes accepted in the current or most recent walk |

## Verification
After a start sampled at a clock edge, the first request is visible from the next edge, and `bytes_issued` reads 0 from that same edge. An accepted request is replaced, or followed by the `done` pulse, from the edge that accepts it. An error flag appears on the edge after the cycle in which `rd_err` was high. The bench drives every input at the falling edge and reads the outputs at the following falling edge, after exactly one rising edge has passed. Each expected value is therefore compared in the half-cycle where that register has just changed.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int NFRAG    = 5;
  localparam int NEXT     = 3;
  localparam int PAGE_LG2 = 12;
  localparam int SLOT_W   = $clog2(NFRAG);

  typedef enum logic {
    WALK_LINE = 1'b0,
    WALK_FRAG = 1'b1
  } walk_mode_e;
endpackage

// File: rtl/prg_src_unpack.sv
module prg_src_unpack
  import prg_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic [NFRAG-1:0][31:0]       src_lo,
  input  logic [NEXT-1:0][31:0]        ext_words,
  output logic [NFRAG-1:0][ADDR_W-1:0] src_addr
);
  // even slots take the high 12-bit field at <<20, odd slots the low field at <<8
  for (genvar k = 0; k < NFRAG; k++) begin : g_slot
    if (k % 2 == 0) begin : g_hi
      assign src_addr[k] = ADDR_W'(src_lo[k])
                         + (ADDR_W'(ext_words[k/2][27:16]) << 20);
    end else begin : g_lo
      assign src_addr[k] = ADDR_W'(src_lo[k])
                         + (ADDR_W'(ext_words[(k+1)/2][11:0]) << 8);
    end
  end
endmodule

// File: rtl/prg_len_sel.sv
module prg_len_sel
  import prg_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 32
) (
  input  walk_mode_e        mode,
  input  logic [LEN_W-1:0]  line_len,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  remaining,
  input  logic              last_slot,
  output logic [LEN_W-1:0]  req_len,
  output logic              is_last
);
  localparam logic [LEN_W-1:0] PAGE_BYTES = LEN_W'(1 << PAGE_LG2);

  logic [LEN_W-1:0] page_room;
  logic [LEN_W-1:0] raw_len;
  logic             fits;

  always_comb begin
    page_room = PAGE_BYTES - LEN_W'(addr[PAGE_LG2-1:0]);
    raw_len   = (mode == WALK_FRAG) ? page_room : line_len;
    fits      = (remaining <= raw_len);
    req_len   = fits ? remaining : raw_len;
    is_last   = fits || ((mode == WALK_FRAG) && last_slot);
  end
endmodule

// File: rtl/pyld_rdreq_gen.sv
module pyld_rdreq_gen
  import prg_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 32,
  parameter int CH_W   = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CH_W-1:0]       start_ch,
  input  logic                  frag_mode,
  input  logic [LEN_W-1:0]      xfer_size,
  input  logic [31:0]           size_stride,
  input  logic [NFRAG-1:0][31:0] src_lo,
  input  logic [NEXT-1:0][31:0]  ext_words,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [ADDR_W-1:0]     req_addr,
  output logic [LEN_W-1:0]      req_len,
  input  logic                  rd_err,
  output logic                  done,
  output logic [NCH-1:0]        data_err,
  output logic [LEN_W-1:0]      bytes_issued
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // state
  logic                        busy_q, busy_d;
  walk_mode_e                  mode_q, mode_d;
  logic [CH_W-1:0]             ch_q, ch_d;
  logic [LEN_W-1:0]            rem_q, rem_d;
  logic [ADDR_W-1:0]           stride_q, stride_d;
  logic [LEN_W-1:0]            line_q, line_d;
  logic [SLOT_W-1:0]           slot_q, slot_d;
  logic [NFRAG-1:0][ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]            cnt_q, cnt_d;
  logic                        done_q, done_d;
  logic [NCH-1:0]              err_q, err_d;

  logic [NFRAG-1:0][ADDR_W-1:0] src_addr;
  logic [ADDR_W-1:0]           cur_addr;
  logic [LEN_W-1:0]            cur_len;
  logic                        cur_last;
  logic                        empty_desc;
  logic                        state_en;

  prg_src_unpack #(.ADDR_W(ADDR_W)) u_unpack (
    .src_lo    (src_lo),
    .ext_words (ext_words),
    .src_addr  (src_addr)
  );

  assign cur_addr = addr_q[slot_q];

  prg_len_sel #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_len (
    .mode      (mode_q),
    .line_len  (line_q),
    .addr      (cur_addr),
    .remaining (rem_q),
    .last_slot (slot_q == SLOT_W'(NFRAG-1)),
    .req_len   (cur_len),
    .is_last   (cur_last)
  );

  assign empty_desc = (xfer_size == '0)
                    || (!frag_mode && (size_stride[17:0] == 18'd0));

  // next state
  always_comb begin
    busy_d   = busy_q;
    mode_d   = mode_q;
    ch_d     = ch_q;
    rem_d    = rem_q;
    stride_d = stride_q;
    line_d   = line_q;
    slot_d   = slot_q;
    addr_d   = addr_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    err_d    = '0;
    if (!busy_q) begin
      if (start) begin
        mode_d   = frag_mode ? WALK_FRAG : WALK_LINE;
        ch_d     = start_ch;
        rem_d    = xfer_size;
        stride_d = ADDR_W'({size_stride[31:18], 4'b0000});
        line_d   = LEN_W'(size_stride[17:0]);
        slot_d   = '0;
        addr_d   = src_addr;
        cnt_d    = '0;
        if (empty_desc) done_d = 1'b1;
        else            busy_d = 1'b1;
      end
    end else if (rd_err) begin
      busy_d      = 1'b0;
      done_d      = 1'b1;
      err_d[ch_q] = 1'b1;
    end else if (req_ready) begin
      cnt_d = cnt_q + cur_len;
      rem_d = rem_q - cur_len;
      if (mode_q == WALK_FRAG) slot_d = slot_q + 1'b1;
      else                     addr_d[0] = addr_q[0] + stride_q;
      if (cur_last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  // explicit clock enable for the wide payload state
  assign state_en = busy_q ? (rd_err || req_ready) : start;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q   <= 1'b0;
      mode_q   <= WALK_LINE;
      ch_q     <= '0;
      rem_q    <= '0;
      stride_q <= '0;
      line_q   <= '0;
      slot_q   <= '0;
      addr_q   <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= '0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
      if (state_en) begin
        busy_q   <= busy_d;
        mode_q   <= mode_d;
        ch_q     <= ch_d;
        rem_q    <= rem_d;
        stride_q <= stride_d;
        line_q   <= line_d;
        slot_q   <= slot_d;
        addr_q   <= addr_d;
        cnt_q    <= cnt_d;
      end
    end
  end

  assign req_valid    = busy_q;
  assign req_addr     = cur_addr;
  assign req_len      = cur_len;
  assign done         = done_q;
  assign data_err     = err_q;
  assign bytes_issued = cnt_q;
endmodule

// File: rtl/prg_chk.sv
module prg_chk #(
  parameter int NCH    = 6,
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              rd_err,
  input logic              done,
  input logic [NCH-1:0]    data_err,
  input logic [LEN_W-1:0]  rem,
  input logic              start,
  input logic [LEN_W-1:0]  xfer_size
);
  // R7
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !rd_err |=> req_valid && $stable(req_addr) && $stable(req_len));

  // R6
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (req_len <= rem));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rd_err |=> done && !req_valid && (data_err != '0));

  // R9
  err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_err));

  // R12
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  // R8
  empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !req_valid && (xfer_size == '0) |=> done && !req_valid);
endmodule

bind pyld_rdreq_gen prg_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_prg_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_len   (req_len),
  .rd_err    (rd_err),
  .done      (done),
  .data_err  (data_err),
  .rem       (rem_q),
  .start     (start),
  .xfer_size (xfer_size)
);

// File: tb/pyld_rdreq_gen_tb.sv
module pyld_rdreq_gen_tb;
  localparam int NCH = 6;
  localparam int CH_W = 3;
  localparam int AW = 48;
  localparam int LW = 32;

  typedef struct packed {
    logic             mode;
    logic [31:0]      xfer;
    logic [31:0]      szstr;
    logic [4:0][31:0] src;
    logic [2:0][31:0] ext;
    logic [31:0]      n;
    logic [31:0]      total;
    logic [47:0]      first_addr;
    logic [31:0]      first_len;
    logic [47:0]      sec_addr;
    logic [47:0]      last_addr;
    logic [31:0]      last_len;
  } vec_t;

  localparam vec_t VECS [6] = '{
    // line: 100 B, 40 B lines, stride 4*16
    '{1'b0, 32'd100, 32'h0010_0028, {32'h0, 32'h0, 32'h0, 32'h0, 32'h1000}, {32'h0, 32'h0, 32'h0},
      32'd3, 32'd100, 48'h1000, 32'd40, 48'h1040, 48'h1080, 32'd20},
    // line: one line, ext0 high field 3
    '{1'b0, 32'd64, 32'h0040_0040, {32'h0, 32'h0, 32'h0, 32'h0, 32'h2000}, {32'h0, 32'h0, 32'h0003_0000},
      32'd1, 32'd64, 48'h30_2000, 32'd64, 48'h0, 48'h30_2000, 32'd64},
    // line: exact multiple
    '{1'b0, 32'd96, 32'h0008_0020, {32'h0, 32'h0, 32'h0, 32'h0, 32'h100}, {32'h0, 32'h0, 32'h0},
      32'd3, 32'd96, 48'h100, 32'd32, 48'h120, 48'h140, 32'd32},
    // fragments: unaligned starts, ext1 low field 1
    '{1'b1, 32'd10000, 32'h0, {32'h0, 32'h9800, 32'h7000, 32'h5000, 32'h0F00}, {32'h0, 32'h1, 32'h0},
      32'd4, 32'd10000, 48'h0F00, 32'd256, 48'h5100, 48'h9800, 32'd1808},
    // fragments: fifth clamped, ext2 high field 2
    '{1'b1, 32'd20000, 32'h0, {32'h50000, 32'h40000, 32'h30000, 32'h20000, 32'h10000}, {32'h0002_0000, 32'h0, 32'h0},
      32'd5, 32'd20000, 48'h10000, 32'd4096, 48'h20000, 48'h25_0000, 32'd3616},
    // fragments: runs out of slots
    '{1'b1, 32'd30000, 32'h0, {32'h50000, 32'h40000, 32'h30000, 32'h20000, 32'h10000}, {32'h0, 32'h0, 32'h0},
      32'd5, 32'd20480, 48'h10000, 32'd4096, 48'h20000, 48'h5_0000, 32'd4096}
  };

  logic                  clk;
  logic                  rst_n;
  logic                  start;
  logic [CH_W-1:0]       start_ch;
  logic                  frag_mode;
  logic [LW-1:0]         xfer_size;
  logic [31:0]           size_stride;
  logic [4:0][31:0]      src_lo;
  logic [2:0][31:0]      ext_words;
  logic                  req_valid;
  logic                  req_ready;
  logic [AW-1:0]         req_addr;
  logic [LW-1:0]         req_len;
  logic                  rd_err;
  logic                  done;
  logic [NCH-1:0]        data_err;
  logic [LW-1:0]         bytes_issued;

  int total_chk;
  int bad_chk;
  bit finished;

  pyld_rdreq_gen #(.NCH(NCH), .ADDR_W(AW), .LEN_W(LW)) u_dut (
    .clk (clk), .rst_n (rst_n), .start (start), .start_ch (start_ch),
    .frag_mode (frag_mode), .xfer_size (xfer_size), .size_stride (size_stride),
    .src_lo (src_lo), .ext_words (ext_words), .req_valid (req_valid),
    .req_ready (req_ready), .req_addr (req_addr), .req_len (req_len),
    .rd_err (rd_err), .done (done), .data_err (data_err),
    .bytes_issued (bytes_issued)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  endtask

  task automatic load(input vec_t v, input logic [CH_W-1:0] ch);
    frag_mode   = v.mode;
    xfer_size   = v.xfer;
    size_stride = v.szstr;
    src_lo      = v.src;
    ext_words   = v.ext;
    start_ch    = ch;
  endtask

  // call at a falling edge; returns at the falling edge where done is seen
  task automatic collect(input bit stall, output int n, output logic [47:0] a0, output logic [47:0] a1,
                         output logic [31:0] l0, output logic [47:0] al, output logic [31:0] ll,
                         output bit done_ok);
    bit prev_acc;
    int cyc;
    n = 0; prev_acc = 0; done_ok = 0; cyc = 0;
    a0 = '0; a1 = '0; l0 = '0; al = '0; ll = '0;
    forever begin
      if (done) begin
        done_ok = prev_acc;
        break;
      end
      req_ready = !(stall && (cyc % 3 == 1));
      prev_acc = 0;
      if (req_valid && req_ready) begin
        if (n == 0) begin a0 = req_addr; l0 = req_len; end
        if (n == 1) a1 = req_addr;
        al = req_addr; ll = req_len;
        n++;
        prev_acc = 1;
      end
      cyc++;
      if (cyc > 2000) begin
        check(0, "collect timeout", 64'(cyc), 64'd0);
        break;
      end
      @(negedge clk);
    end
    req_ready = 1'b0;
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", 64'd0, 64'd1);
      finish_run();
    end
  end

  initial begin : main
    int n;
    logic [47:0] a0, a1, al;
    logic [31:0] l0, ll;
    bit dok;
    total_chk = 0; bad_chk = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0; req_ready = 1'b0; rd_err = 1'b0;
    load(VECS[0], '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(req_valid == 1'b0, "R1 req_valid", 64'(req_valid), 64'd0);
    check(done == 1'b0, "R1 done", 64'(done), 64'd0);
    check(data_err == '0, "R1 data_err", 64'(data_err), 64'd0);
    check(bytes_issued == '0, "R1 bytes_issued", 64'(bytes_issued), 64'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R10 R12
    for (int i = 0; i < 6; i++) begin
      load(VECS[i], CH_W'(i % NCH));
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(bytes_issued == '0, "R10 cleared at start", 64'(bytes_issued), 64'd0);
      collect(i % 2 == 1, n, a0, a1, l0, al, ll, dok);
      check(n == int'(VECS[i].n), "R3/R4 request count", 64'(n), 64'(VECS[i].n));
      check(a0 == VECS[i].first_addr, "R5 first address", 64'(a0), 64'(VECS[i].first_addr));
      check(l0 == VECS[i].first_len, "R2/R4 first length", 64'(l0), 64'(VECS[i].first_len));
      if (VECS[i].n > 1)
        check(a1 == VECS[i].sec_addr, "R2/R5 second address", 64'(a1), 64'(VECS[i].sec_addr));
      check(al == VECS[i].last_addr, "R3/R5 last address", 64'(al), 64'(VECS[i].last_addr));
      check(ll == VECS[i].last_len, "R6 last length", 64'(ll), 64'(VECS[i].last_len));
      check(bytes_issued == VECS[i].total, "R10 byte total", 64'(bytes_issued), 64'(VECS[i].total));
      check(dok, "R12 done follows last accept", 64'(dok), 64'd1);
      check(data_err == '0, "R9 no error on clean walk", 64'(data_err), 64'd0);
      @(negedge clk);
      check(done == 1'b0, "R12 done one cycle", 64'(done), 64'd0);
      check(bytes_issued == VECS[i].total, "R10 held after done", 64'(bytes_issued), 64'(VECS[i].total));
    end

    // R8 zero line length in line mode
    load(VECS[0], '0);
    xfer_size = 32'd50;
    size_stride = 32'h0010_0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R8 zero line done", 64'(done), 64'd1);
    check(req_valid == 1'b0, "R8 zero line no request", 64'(req_valid), 64'd0);
    @(negedge clk);
    check(done == 1'b0 && req_valid == 1'b0, "R8 zero line quiet", 64'({done, req_valid}), 64'd0);

    // R8 zero transfer in fragment mode
    load(VECS[3], '0);
    xfer_size = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1 && req_valid == 1'b0, "R8 zero size", 64'({done, req_valid}), 64'b10);
    check(bytes_issued == '0, "R8 zero size bytes", 64'(bytes_issued), 64'd0);
    @(negedge clk);

    // R9 read error on second request, channel 2
    load(VECS[0], CH_W'(2));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    req_ready = 1'b1;
    @(negedge clk);
    check(req_valid && req_addr == 48'h1040, "R9 second request shown", 64'(req_addr), 64'h1040);
    rd_err = 1'b1;
    @(negedge clk);
    rd_err = 1'b0;
    check(done == 1'b1, "R9 done on error", 64'(done), 64'd1);
    check(data_err == 6'b000100, "R9 channel error bit", 64'(data_err), 64'h4);
    check(req_valid == 1'b0, "R9 no further request", 64'(req_valid), 64'd0);
    check(bytes_issued == 32'd40, "R9 rejected not counted", 64'(bytes_issued), 64'd40);
    @(negedge clk);
    check(data_err == '0 && req_valid == 1'b0, "R9 error one cycle", 64'({data_err, req_valid}), 64'd0);
    req_ready = 1'b0;

    // R11 start while busy is ignored
    load(VECS[2], '0);
    start = 1'b1;
    @(negedge clk);
    load(VECS[0], '0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req_addr == 48'h100 && req_len == 32'd32, "R11 request unchanged", 64'(req_addr), 64'h100);
    collect(1'b0, n, a0, a1, l0, al, ll, dok);
    check(n == 3 && bytes_issued == 32'd96, "R11 original walk completes", 64'(bytes_issued), 64'd96);
    check(al == 48'h140, "R11 original last address", 64'(al), 64'h140);

    repeat (3) @(negedge clk);
    finished = 1;
    finish_run();
  end
endmodule